// File: doc/BRIEF.md
# Trimmed Seconds Counter with Tick Interrupt

This block keeps wall-clock time in whole seconds. It runs from a slow timebase clock with a nominal rate of 32000 Hz. A sub-second divider turns those input ticks into one pulse per second, and each pulse advances a 32-bit seconds register. The divider can be trimmed by a signed correction expressed in units of 2^-20 of the rate. With that correction, a 32.768 kHz crystal can drive a divider built for 32 kHz: the setting is a magnitude of 24576 with the direction bit clear.

Software reaches the block over a simple register bus in a fast clock domain. Writes to the control and seconds registers cross into the slow domain through a toggle handshake, and a busy flag for each stays set while its write is in flight. Each seconds update is published back into the fast domain as a whole word, so a read never sees a half-updated value. A per-second event can raise an interrupt. The interrupt has its own enable and a write-one-to-clear status flag.

Each write crossing is run by a two-state machine. In IDLE, an accepted write captures its payload, flips the request toggle and moves to WAIT. In WAIT, further writes are refused. The machine returns to IDLE once the acknowledge toggle, synchronised back into the source domain, matches the request toggle again.

Top module: `secs_rtc`

## Requirements
- R1: After reset, all four registers read 0 and `sec_irq` is low.
- R2: With trimming disabled, the seconds register advances by one for every TICKS_PER_SEC slow-clock ticks, and the sub-second count always stays below TICKS_PER_SEC.
- R3: With trimming enabled and the direction bit (CAL bit 20) clear, every carry out of the 20-bit accumulator swallows that input tick. A magnitude of 2^19 therefore stretches a second to 2*TICKS_PER_SEC ticks.
- R4: With trimming enabled and the direction bit set, every accumulator carry counts that input tick twice. A magnitude of 2^19 gives 3 counts per 2 input ticks.
- R5: The CAL register (address 1, magnitude in bits 19:0, direction in bit 20) reaches the slow domain only with the next CTRL write. CTRL bit 0 enables trimming; while it is 0 the divider counts raw ticks whatever CAL holds.
- R6: Writing CTRL (address 0) with bit 2 set clears the sub-second count and the accumulator. Bit 2 is not stored and reads back as 0.
- R7: A write to SEC (address 2) loads the slow-domain seconds register. A read of SEC returns the last complete value published from the slow domain.
- R8: STATUS (address 3) bit 0 is the seconds-write busy flag and bit 1 is the control-write busy flag. Each reads 1 from the cycle after an accepted write until its handshake completes.
- R9: A write to SEC or CTRL while that register's busy flag is set is discarded.
- R10: CTRL bit 1 enables the tick interrupt. While it is set, a seconds tick sets STATUS bit 2. `sec_irq` equals STATUS bit 2 ANDed with the enable bit.
- R11: Writing 1 to STATUS bit 2 clears it and writing 0 leaves it unchanged. A tick that arrives in the same cycle as a clear leaves the flag set.
- R12: The seconds register wraps from 0xFFFFFFFF to 0 on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast register-bus clock |
| slow_clk | input | 1 | Nominal 32 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 CTRL, 1 CAL, 2 SEC, 3 STATUS |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| sec_irq | output | 1 | Per-second interrupt request |

## Verification
The bench aligns the sub-second phase, then reads the seconds value half a second after each expected boundary. A divider with an off-by-one limit, or a trim that swallows on the wrong direction or adds the wrong extra count, lands on a different second count. It issues back-to-back seconds writes to confirm that the second write is dropped and that busy is visible straight away; a design without the guard would overwrite an in-flight value. It probes the interrupt flag with a clear write of 0, with the enable removed while the flag is set, and with ticks arriving while disabled. A flag tied to the wrong gate, or cleared by any write, shows up in those reads. It also runs the seconds value across the 32-bit wrap.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CAL  = 2'd1,
        REG_SEC  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    // CTRL bit positions
    localparam int CTRL_TRIM_EN = 0;
    localparam int CTRL_IRQ_EN  = 1;
    localparam int CTRL_ZERO    = 2;

    // STATUS bit positions
    localparam int STAT_SEC_BUSY  = 0;
    localparam int STAT_CTRL_BUSY = 1;
    localparam int STAT_TICK      = 2;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_WAIT = 1'b1
    } xfer_state_e;
endpackage

// File: rtl/secs_rtc_xfer.sv
module secs_rtc_xfer
    import secs_rtc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         src_clk,
    input  logic         dst_clk,
    input  logic         rst_n,
    input  logic         src_load,
    input  logic [W-1:0] src_data,
    output logic         src_busy,
    output logic         dst_pulse,
    output logic [W-1:0] dst_data
);
    xfer_state_e state_q, state_d;
    logic         req_q;
    logic [W-1:0] hold_q;
    logic [2:0]   req_sync_q;
    logic [1:0]   ack_sync_q;
    logic         ack_back;
    logic         accept;

    assign ack_back = (ack_sync_q[1] == req_q);
    assign accept   = (state_q == XF_IDLE) && src_load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (src_load) state_d = XF_WAIT;
            XF_WAIT: if (ack_back) state_d = XF_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    // source-side payload, request toggle and acknowledge synchroniser
    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            hold_q     <= '0;
            ack_sync_q <= '0;
        end else begin
            ack_sync_q <= {ack_sync_q[0], req_sync_q[2]};
            if (accept) begin
                hold_q <= src_data;
                req_q  <= ~req_q;
            end
        end
    end

    // destination-side request synchroniser
    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) req_sync_q <= '0;
        else        req_sync_q <= {req_sync_q[1:0], req_q};
    end

    // outputs
    always_comb begin
        src_busy  = (state_q == XF_WAIT);
        dst_pulse = req_sync_q[2] ^ req_sync_q[1];
        dst_data  = hold_q;
    end
endmodule

// File: rtl/secs_rtc_trim.sv
module secs_rtc_trim #(
    parameter int TICKS  = 32000,
    parameter int FRAC_W = 20,
    localparam int CNT_W = $clog2(TICKS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              trim_en,
    input  logic              trim_up,
    input  logic [FRAC_W-1:0] trim_mag,
    output logic              sec_tick,
    output logic [CNT_W-1:0]  sub_cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TICKS);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic [1:0]        step;
    logic [CNT_W-1:0]  cnt_q, cnt_sum;
    logic              wrap;

    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, trim_mag};
        carry   = trim_en & acc_sum[FRAC_W];
        if (!carry)      step = 2'd1;
        else if (trim_up) step = 2'd2;
        else             step = 2'd0;
        cnt_sum = cnt_q + CNT_W'(step);
        wrap    = (cnt_sum >= LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            sec_tick <= 1'b0;
        end else if (clear) begin
            acc_q    <= '0;
            cnt_q    <= '0;
            sec_tick <= 1'b0;
        end else begin
            if (trim_en) acc_q <= acc_sum[FRAC_W-1:0];
            cnt_q    <= wrap ? cnt_sum - LIMIT : cnt_sum;
            sec_tick <= wrap;
        end
    end

    assign sub_cnt = cnt_q;
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
    import secs_rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32000,
    parameter int FRAC_W        = 20
) (
    input  logic        bus_clk,
    input  logic        slow_clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sec_irq
);
    localparam int SEC_W   = 32;
    localparam int CNT_W   = $clog2(TICKS_PER_SEC + 2);
    localparam int CTRL_XW = FRAC_W + 3;
    localparam int PUB_W   = SEC_W + 1;
    localparam int CAL_PAD = 31 - FRAC_W;

    // ---------------- fast domain ----------------
    reg_sel_e          sel;
    logic              wr_cyc, rd_cyc;
    logic [1:0]        ctrl_q;
    logic [FRAC_W-1:0] cal_mag_q;
    logic              cal_up_q;
    logic [SEC_W-1:0]  sec_view_q;
    logic              flag_q, flag_d;
    logic              ctrl_load, sec_load, clear_req, tick_evt;
    logic              ctrl_busy, sec_busy;
    logic              pub_pulse;
    logic [PUB_W-1:0]  pub_data;

    // ---------------- slow domain ----------------
    logic               ctrl_pulse, sec_pulse;
    logic [CTRL_XW-1:0] ctrl_xdata;
    logic [SEC_W-1:0]   sec_xdata;
    logic               s_trim_en_q, s_trim_up_q;
    logic [FRAC_W-1:0]  s_trim_mag_q;
    logic               s_clear, s_tick;
    logic [CNT_W-1:0]   sub_cnt;
    logic [SEC_W-1:0]   s_sec_q;
    logic               pend_q, pend_tick_q, pub_load, pub_busy;

    assign sel       = reg_sel_e'(bus_addr);
    assign wr_cyc    = bus_sel & bus_wr;
    assign rd_cyc    = bus_sel & ~bus_wr;
    assign ctrl_load = wr_cyc && (sel == REG_CTRL) && !ctrl_busy;
    assign sec_load  = wr_cyc && (sel == REG_SEC) && !sec_busy;
    assign clear_req = wr_cyc && (sel == REG_STAT) && bus_wdata[STAT_TICK];
    assign tick_evt  = pub_pulse & pub_data[SEC_W];

    always_comb begin
        if (tick_evt && ctrl_q[CTRL_IRQ_EN]) flag_d = 1'b1;
        else if (clear_req)                  flag_d = 1'b0;
        else                                 flag_d = flag_q;
    end

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            cal_mag_q  <= '0;
            cal_up_q   <= 1'b0;
            sec_view_q <= '0;
            flag_q     <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            flag_q <= flag_d;
            if (ctrl_load) ctrl_q <= bus_wdata[1:0];
            if (wr_cyc && sel == REG_CAL) begin
                cal_mag_q <= bus_wdata[FRAC_W-1:0];
                cal_up_q  <= bus_wdata[FRAC_W];
            end
            if (pub_pulse) sec_view_q <= pub_data[SEC_W-1:0];
            if (rd_cyc) begin
                unique case (sel)
                    REG_CTRL: bus_rdata <= {30'b0, ctrl_q};
                    REG_CAL:  bus_rdata <= {{CAL_PAD{1'b0}}, cal_up_q, cal_mag_q};
                    REG_SEC:  bus_rdata <= sec_view_q;
                    REG_STAT: bus_rdata <= {29'b0, flag_q, ctrl_busy, sec_busy};
                endcase
            end
        end
    end

    assign sec_irq = flag_q & ctrl_q[CTRL_IRQ_EN];

    // control + calibration crossing
    secs_rtc_xfer #(.W(CTRL_XW)) u_ctrl_xfer (
        .src_clk  (bus_clk),
        .dst_clk  (slow_clk),
        .rst_n    (rst_n),
        .src_load (ctrl_load),
        .src_data ({bus_wdata[CTRL_ZERO], bus_wdata[CTRL_TRIM_EN], cal_up_q, cal_mag_q}),
        .src_busy (ctrl_busy),
        .dst_pulse(ctrl_pulse),
        .dst_data (ctrl_xdata)
    );

    // seconds write crossing
    secs_rtc_xfer #(.W(SEC_W)) u_sec_xfer (
        .src_clk  (bus_clk),
        .dst_clk  (slow_clk),
        .rst_n    (rst_n),
        .src_load (sec_load),
        .src_data (bus_wdata),
        .src_busy (sec_busy),
        .dst_pulse(sec_pulse),
        .dst_data (sec_xdata)
    );

    // slow-domain control registers
    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            s_trim_en_q  <= 1'b0;
            s_trim_up_q  <= 1'b0;
            s_trim_mag_q <= '0;
        end else if (ctrl_pulse) begin
            s_trim_en_q  <= ctrl_xdata[FRAC_W+1];
            s_trim_up_q  <= ctrl_xdata[FRAC_W];
            s_trim_mag_q <= ctrl_xdata[FRAC_W-1:0];
        end
    end

    assign s_clear = ctrl_pulse & ctrl_xdata[FRAC_W+2];

    secs_rtc_trim #(.TICKS(TICKS_PER_SEC), .FRAC_W(FRAC_W)) u_trim (
        .clk     (slow_clk),
        .rst_n   (rst_n),
        .clear   (s_clear),
        .trim_en (s_trim_en_q),
        .trim_up (s_trim_up_q),
        .trim_mag(s_trim_mag_q),
        .sec_tick(s_tick),
        .sub_cnt (sub_cnt)
    );

    // seconds register and publication request
    assign pub_load = pend_q & ~pub_busy;

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            s_sec_q     <= '0;
            pend_q      <= 1'b0;
            pend_tick_q <= 1'b0;
        end else begin
            if (sec_pulse)   s_sec_q <= sec_xdata;
            else if (s_tick) s_sec_q <= s_sec_q + 1'b1;
            pend_q      <= (pend_q & ~pub_load) | sec_pulse | s_tick;
            pend_tick_q <= (pend_tick_q & ~pub_load) | s_tick;
        end
    end

    secs_rtc_xfer #(.W(PUB_W)) u_pub_xfer (
        .src_clk  (slow_clk),
        .dst_clk  (bus_clk),
        .rst_n    (rst_n),
        .src_load (pub_load),
        .src_data ({pend_tick_q, s_sec_q}),
        .src_busy (pub_busy),
        .dst_pulse(pub_pulse),
        .dst_data (pub_data)
    );
endmodule

// File: rtl/secs_rtc_chk.sv
module secs_rtc_chk #(
    parameter int TICKS = 32000,
    parameter int CNT_W = 15,
    parameter int SEC_W = 32
) (
    input logic             bus_clk,
    input logic             slow_clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             clr_bit,
    input logic             sec_busy,
    input logic             ctrl_busy,
    input logic [SEC_W-1:0] sec_hold,
    input logic             tick_evt,
    input logic             irq_en,
    input logic             flag,
    input logic             s_tick,
    input logic             s_sec_load,
    input logic [SEC_W-1:0] s_sec,
    input logic             s_clear,
    input logic [CNT_W-1:0] sub_cnt
);
    logic wr_sec, wr_ctrl, wr_clr;
    assign wr_sec  = bus_sel && bus_wr && bus_addr == 2'd2;
    assign wr_ctrl = bus_sel && bus_wr && bus_addr == 2'd0;
    assign wr_clr  = bus_sel && bus_wr && bus_addr == 2'd3 && clr_bit;

    assert_sec_busy_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (wr_sec && !sec_busy) |=> sec_busy);
    assert_ctrl_busy_R8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (wr_ctrl && !ctrl_busy) |=> ctrl_busy);
    assert_drop_busy_R9: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (wr_sec && sec_busy) |=> $stable(sec_hold));
    assert_tick_wins_R11: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (tick_evt && irq_en) |=> flag);
    assert_flag_sticky_R11: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (flag && !wr_clr) |=> flag);
    assert_no_stray_flag_R10: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (!flag && !(tick_evt && irq_en)) |=> !flag);
    assert_sec_step_R2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (s_tick && !s_sec_load) |=> s_sec == $past(s_sec) + 1'b1);
    assert_sec_hold_R7: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!s_tick && !s_sec_load) |=> $stable(s_sec));
    assert_sec_wrap_R12: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (s_tick && !s_sec_load && s_sec == '1) |=> s_sec == '0);
    assert_phase_clear_R6: assert property (@(posedge slow_clk) disable iff (!rst_n)
        s_clear |=> sub_cnt == '0);
    assert_phase_bound_R2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        sub_cnt < CNT_W'(TICKS));
endmodule

bind secs_rtc secs_rtc_chk #(.TICKS(TICKS_PER_SEC), .CNT_W(CNT_W), .SEC_W(SEC_W)) u_chk (
    .bus_clk   (bus_clk),
    .slow_clk  (slow_clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .clr_bit   (bus_wdata[2]),
    .sec_busy  (sec_busy),
    .ctrl_busy (ctrl_busy),
    .sec_hold  (sec_xdata),
    .tick_evt  (tick_evt),
    .irq_en    (ctrl_q[1]),
    .flag      (flag_q),
    .s_tick    (s_tick),
    .s_sec_load(sec_pulse),
    .s_sec     (s_sec_q),
    .s_clear   (s_clear),
    .sub_cnt   (sub_cnt)
);

// File: tb/secs_rtc_tb.sv
module secs_rtc_tb;
    localparam int N = 64;

    logic        bus_clk  = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n    = 1'b0;
    logic        bus_sel  = 1'b0;
    logic        bus_wr   = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit model_ien = 1'b0;
    logic [31:0] rv;

    always #2  bus_clk  = ~bus_clk;
    always #20 slow_clk = ~slow_clk;

    secs_rtc #(.TICKS_PER_SEC(N), .FRAC_W(20)) u_dut (
        .bus_clk  (bus_clk),
        .slow_clk (slow_clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .sec_irq  (sec_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model of the enable bit (R10)
    always @(negedge bus_clk) begin
        if (rst_n) begin
            n_vec++;
            if (sec_irq && !model_ien) begin
                n_bad++;
                $display("FAIL R10: actual sec_irq=1 expected 0 while disabled");
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge bus_clk);
        #1;
        if (a == 2'd0) model_ien = d[1];
        @(negedge bus_clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge bus_clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 300; i++) begin
            rd(2'd3, s);
            if (s[1:0] == 2'b00) break;
        end
    endtask

    task automatic slow(input int n);
        repeat (n) @(posedge slow_clk);
    endtask

    // zero the phase with the given control bits, then load seconds
    task automatic align(input logic [31:0] ctrl, input logic [31:0] secs);
        wr(2'd0, ctrl | 32'h4);
        wait_idle();
        wr(2'd2, secs);
        wait_idle();
        slow(4);
    endtask

    initial begin
        #400_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge bus_clk);
        rst_n = 1'b1;
        slow(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], rv);
            check("R1", rv, 32'h0);
        end
        check("R1", {31'b0, sec_irq}, 32'h0);

        // R2 raw rate, R6 zero bit reads back 0
        align(32'h0, 32'd100);
        rd(2'd0, rv);
        check("R6", rv, 32'h0);
        slow(3 * N + N / 2);
        rd(2'd2, rv);
        check("R2", rv, 32'd103);

        // R7 whole-value readback, R12 wrap
        align(32'h0, 32'hFFFF_FFFF);
        rd(2'd2, rv);
        check("R7", rv, 32'hFFFF_FFFF);
        slow(N + N / 2);
        rd(2'd2, rv);
        check("R12", rv, 32'h0);

        // R5 calibration loaded but trimming disabled: raw rate
        wr(2'd1, 32'h0008_0000);
        rd(2'd1, rv);
        check("R5", rv, 32'h0008_0000);
        align(32'h0, 32'd0);
        slow(2 * N + N / 2);
        rd(2'd2, rv);
        check("R5", rv, 32'd2);

        // R3 negative trim, magnitude 2^19: second = 2N ticks
        align(32'h1, 32'd0);
        slow(4 * N + N);
        rd(2'd2, rv);
        check("R3", rv, 32'd2);

        // R4 positive trim, magnitude 2^19: 3 counts per 2 ticks
        wr(2'd1, 32'h0018_0000);
        align(32'h1, 32'd0);
        slow(140);
        rd(2'd2, rv);
        check("R4", rv, 32'd3);

        // R8 busy flags, R9 write during busy dropped
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h4);
        rd(2'd3, rv);
        check("R8", {30'b0, rv[1:0]}, 32'h2);
        wait_idle();
        rd(2'd3, rv);
        check("R8", {30'b0, rv[1:0]}, 32'h0);
        wr(2'd2, 32'd500);
        wr(2'd2, 32'd900);
        rd(2'd3, rv);
        check("R8", {31'b0, rv[0]}, 32'h1);
        wait_idle();
        slow(4);
        rd(2'd2, rv);
        check("R9", rv, 32'd500);

        // R10 / R11 interrupt flag behaviour
        align(32'h2, 32'd0);
        slow(N + N / 2);
        rd(2'd3, rv);
        check("R10", rv, 32'h4);
        check("R10", {31'b0, sec_irq}, 32'h1);
        wr(2'd3, 32'h0);
        rd(2'd3, rv);
        check("R11", rv, 32'h4);
        wr(2'd3, 32'h4);
        rd(2'd3, rv);
        check("R11", rv, 32'h0);
        check("R11", {31'b0, sec_irq}, 32'h0);
        wr(2'd0, 32'h0);
        wait_idle();
        slow(N + 8);
        rd(2'd3, rv);
        check("R10", rv, 32'h0);
        wr(2'd0, 32'h2);
        wait_idle();
        slow(N);
        rd(2'd3, rv);
        check("R10", rv, 32'h4);
        wr(2'd0, 32'h0);
        wait_idle();
        check("R10", {31'b0, sec_irq}, 32'h0);
        rd(2'd3, rv);
        check("R10", {29'b0, rv[2:0]}, 32'h4);
        wr(2'd3, 32'h4);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule